// File: doc/BRIEF.md
# Single-to-Half Precision Narrowing Converter

This block takes a 32-bit IEEE-754 single-precision operand and produces the 16-bit half-precision value that a processor's floating-point unit would return for the same conversion. It also returns four exception flags: invalid, overflow, underflow and inexact. Finite values use round to nearest with ties to even, which is the only rounding mode. Values too small for the half normal range become gradual half subnormals and are never flushed to zero.

NaN inputs follow a processor convention. By default the sign is kept, the payload is cut down to the upper fraction bits and the quiet bit is forced on. When the default-NaN mode input is high, every NaN becomes one fixed canonical quiet NaN. An operand is accepted on each cycle in which `valid_i` is high. The result and the flags appear registered one cycle later, together with `valid_o`.

Top module: `fp_s2h_narrow`

## Requirements
- R1: A zero input (exponent and fraction fields all zero) gives a result of zero with the input's sign, 0x0000 or 0x8000, and raises no flag.
- R2: An infinite input (exponent field all ones, fraction zero) gives 0x7C00 or 0xFC00 according to its sign, and raises no flag.
- R3: When default-NaN mode is low, a NaN input (exponent all ones, fraction nonzero) gives sign = input bit 31, exponent field = 0x1F, and fraction = input bits 22:13, with result bit 9 forced to 1.
- R4: When default-NaN mode is high, every NaN input gives 0x7E00.
- R5: The invalid flag is raised only for a signalling NaN: a NaN whose input bit 22 is clear. Quiet NaNs raise no flag.
- R6: A finite nonzero input whose unbiased exponent (input exponent minus 127) is -14 or more is rounded to the 10-bit half fraction with round to nearest, ties to even. A carry out of the fraction increments the exponent. The sign is always kept.
- R7: A finite result whose magnitude is 0x7C00 or more after rounding becomes a same-signed infinity and raises both overflow and inexact. For example, 65520 overflows and 65519.99 gives 0x7BFF.
- R8: An input whose unbiased exponent is below -14 is shifted into the subnormal field and then rounded to nearest even. Exactly 2^-25 rounds to zero, anything just above it gives 0x0001, and a carry may reach the smallest normal value 0x0400. Single subnormal inputs give a signed zero.
- R9: Underflow is raised when the unbiased input exponent is below -14 (tininess is judged before rounding) and the result is inexact. An exactly representable subnormal does not raise underflow.
- R10: Inexact is raised whenever a finite conversion discards nonzero bits or overflows. It is never raised for zero, infinity or NaN inputs.
- R11: `valid_o` is high exactly in the cycle after each cycle in which `valid_i` is high. The result and flags change only at that point and otherwise hold.
- R12: During and after reset, before the first operand, `valid_o`, the result and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand strobe |
| op_i | input | 32 | Single-precision operand |
| dn_mode_i | input | 1 | Replace every NaN with the canonical quiet NaN |
| valid_o | output | 1 | Result strobe, one cycle after valid_i |
| res_o | output | 16 | Half-precision result |
| invalid_o | output | 1 | Signalling NaN seen |
| overflow_o | output | 1 | Result overflowed to infinity |
| underflow_o | output | 1 | Tiny and inexact result |
| inexact_o | output | 1 | Result differs from the exact value |

## Verification
The bench builds the block with its default widths: an 8-bit exponent and 23-bit fraction in, and a 5-bit exponent and 10-bit fraction out. With these widths 13 fraction bits are discarded in the normal range, so exact ties are easy to construct. They also put the overflow boundary at 65520 and take the subnormal shift all the way to its cap at 2^-25 and below. Random operands are concentrated on exponents near the two range edges and on fractions whose low bits form ties. They are mixed with whole-word random values and NaN payloads, with default-NaN mode drawn at random for each operand.

// File: rtl/fp_narrow_pkg.sv
package fp_narrow_pkg;
  typedef enum logic [2:0] {
    CLS_ZERO,
    CLS_FINITE,
    CLS_INF,
    CLS_QNAN,
    CLS_SNAN
  } fp_cls_e;

  typedef struct packed {
    logic invalid;
    logic overflow;
    logic underflow;
    logic inexact;
  } fp_flags_t;
endpackage

// File: rtl/fpn_classify.sv
module fpn_classify
  import fp_narrow_pkg::*;
#(
  parameter int EI = 8,
  parameter int FI = 23
) (
  input  logic [EI-1:0] exp_i,
  input  logic [FI-1:0] frac_i,
  output fp_cls_e       cls_o
);
  logic exp_max, exp_zero, frac_nz;

  assign exp_max  = &exp_i;
  assign exp_zero = ~|exp_i;
  assign frac_nz  = |frac_i;

  always_comb begin
    if (exp_max) begin
      if (!frac_nz)            cls_o = CLS_INF;
      else if (frac_i[FI-1])   cls_o = CLS_QNAN;
      else                     cls_o = CLS_SNAN;
    end else if (exp_zero && !frac_nz) begin
      cls_o = CLS_ZERO;
    end else begin
      cls_o = CLS_FINITE;
    end
  end
endmodule

// File: rtl/fpn_nan_path.sv
module fpn_nan_path #(
  parameter int FI = 23,
  parameter int EO = 5,
  parameter int FO = 10
) (
  input  logic           sign_i,
  input  logic [FI-1:0]  frac_i,
  input  logic           dn_mode_i,
  output logic [EO+FO:0] res_o
);
  localparam int DROP = FI - FO;
  localparam logic [EO+FO:0] DNAN = {1'b0, {EO{1'b1}}, 1'b1, {(FO-1){1'b0}}};

  logic [DROP-1:0] unused_low;
  logic            unused_top;
  assign unused_low = frac_i[DROP-1:0];
  assign unused_top = frac_i[FI-1];

  // top fraction bit is replaced by a forced quiet bit
  assign res_o = dn_mode_i ? DNAN
                           : {sign_i, {EO{1'b1}}, 1'b1, frac_i[FI-2:DROP]};
endmodule

// File: rtl/fpn_round_path.sv
module fpn_round_path #(
  parameter int EI = 8,
  parameter int FI = 23,
  parameter int EO = 5,
  parameter int FO = 10
) (
  input  logic [EI-1:0]    exp_i,
  input  logic [FI-1:0]    frac_i,
  output logic [EO+FO-1:0] mag_o,
  output logic             ovf_o,
  output logic             ufl_o,
  output logic             inx_o
);
  localparam int MW      = FI + 1;
  localparam int DROP    = FI - FO;
  localparam int BI      = (1 << (EI - 1)) - 1;
  localparam int BO      = (1 << (EO - 1)) - 1;
  localparam int EW      = EI + 2;
  localparam int EMIN    = 1 - BO;
  localparam int SHR_CAP = MW + 1;
  localparam int SW      = $clog2(SHR_CAP + 1);
  localparam int MAGW    = EO + FO;

  logic signed [EW-1:0] e_unb, e_bias, deficit;
  logic [MW-1:0]        mant;
  logic [SW-1:0]        shr;
  logic [2*MW-1:0]      wide;
  logic                 tiny, big;

  // input subnormals get the leading one too: they sit far below the half
  // range, so it only feeds the sticky bit
  assign mant   = {1'b1, frac_i};
  assign e_unb  = $signed({2'b00, exp_i}) - $signed(EW'(BI));
  assign e_bias = e_unb + $signed(EW'(BO));
  assign tiny   = e_unb < $signed(EW'(EMIN));
  assign big    = e_unb > $signed(EW'(BO));

  always_comb begin
    deficit = $signed(EW'(EMIN)) - e_unb;
    if (deficit > $signed(EW'(SHR_CAP - DROP))) shr = SW'(SHR_CAP);
    else                                        shr = SW'(DROP) + SW'(deficit);
  end

  assign wide = {mant, {MW{1'b0}}} >> shr;

  logic [MAGW-1:0] pre;
  logic            lsb, grd, stk, rnd, sat;
  logic [MAGW:0]   sum;

  always_comb begin
    if (tiny) begin
      pre = wide[MW +: MAGW];
      lsb = wide[MW];
      grd = wide[MW-1];
      stk = |wide[MW-2:0];
    end else begin
      pre = {e_bias[EO-1:0], frac_i[FI-1:DROP]};
      lsb = frac_i[DROP];
      grd = frac_i[DROP-1];
      stk = |frac_i[DROP-2:0];
    end
  end

  assign rnd = grd & (lsb | stk);
  // carry out of the fraction lands in the exponent field
  assign sum = {1'b0, pre} + (MAGW+1)'(rnd);
  assign sat = big | sum[MAGW] | (&sum[MAGW-1:FO]);

  assign mag_o = sat ? {{EO{1'b1}}, {FO{1'b0}}} : sum[MAGW-1:0];
  assign ovf_o = sat;
  assign inx_o = grd | stk | sat;
  assign ufl_o = tiny & (grd | stk);

  logic [2*MW-1-MW-MAGW:0] unused_wide;
  logic [EW-1-EO:0]        unused_ebias;
  assign unused_wide  = wide[2*MW-1:MW+MAGW];
  assign unused_ebias = e_bias[EW-1:EO];
endmodule

// File: rtl/fp_s2h_narrow.sv
module fp_s2h_narrow
  import fp_narrow_pkg::*;
#(
  parameter int EI = 8,
  parameter int FI = 23,
  parameter int EO = 5,
  parameter int FO = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [EI+FI:0]   op_i,
  input  logic             dn_mode_i,
  output logic             valid_o,
  output logic [EO+FO:0]   res_o,
  output logic             invalid_o,
  output logic             overflow_o,
  output logic             underflow_o,
  output logic             inexact_o
);
  localparam int IW = 1 + EI + FI;
  localparam int OW = 1 + EO + FO;
  localparam logic [OW-1:0] DNAN = {1'b0, {EO{1'b1}}, 1'b1, {(FO-1){1'b0}}};
  localparam logic [OW-2:0] INF_MAG = {{EO{1'b1}}, {FO{1'b0}}};

  logic          sign;
  logic [EI-1:0] exp_f;
  logic [FI-1:0] frac_f;
  assign sign   = op_i[IW-1];
  assign exp_f  = op_i[IW-2:FI];
  assign frac_f = op_i[FI-1:0];

  fp_cls_e       cls;
  logic [OW-1:0] nan_res;
  logic [OW-2:0] fin_mag;
  logic          fin_ovf, fin_ufl, fin_inx;
  logic          in_nan;

  fpn_classify #(.EI(EI), .FI(FI)) u_cls (
    .exp_i (exp_f),
    .frac_i(frac_f),
    .cls_o (cls)
  );

  fpn_nan_path #(.FI(FI), .EO(EO), .FO(FO)) u_nan (
    .sign_i   (sign),
    .frac_i   (frac_f),
    .dn_mode_i(dn_mode_i),
    .res_o    (nan_res)
  );

  fpn_round_path #(.EI(EI), .FI(FI), .EO(EO), .FO(FO)) u_rnd (
    .exp_i (exp_f),
    .frac_i(frac_f),
    .mag_o (fin_mag),
    .ovf_o (fin_ovf),
    .ufl_o (fin_ufl),
    .inx_o (fin_inx)
  );

  assign in_nan = (cls == CLS_QNAN) || (cls == CLS_SNAN);

  logic [OW-1:0] res_d;
  fp_flags_t     flg_d, flg_q;

  always_comb begin
    flg_d = '0;
    unique case (cls)
      CLS_ZERO: res_d = {sign, {(OW-1){1'b0}}};
      CLS_INF:  res_d = {sign, INF_MAG};
      CLS_QNAN: res_d = nan_res;
      CLS_SNAN: begin
        res_d         = nan_res;
        flg_d.invalid = 1'b1;
      end
      default: begin
        res_d           = {sign, fin_mag};
        flg_d.overflow  = fin_ovf;
        flg_d.underflow = fin_ufl;
        flg_d.inexact   = fin_inx;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '0;
      flg_q   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        res_o <= res_d;
        flg_q <= flg_d;
      end
    end
  end

  assign invalid_o   = flg_q.invalid;
  assign overflow_o  = flg_q.overflow;
  assign underflow_o = flg_q.underflow;
  assign inexact_o   = flg_q.inexact;

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);  // R11
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);  // R11
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(res_o));  // R11
  AST_DEFAULT_NAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && dn_mode_i && in_nan |=> res_o == DNAN);  // R4
  AST_QUIET_NAN_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !dn_mode_i && in_nan |=> res_o[FO-1] && (&res_o[OW-2:FO]));  // R3
  AST_SIGN_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !(dn_mode_i && in_nan) |=> res_o[OW-1] == $past(op_i[IW-1]));  // R6
  AST_OVF_IS_INF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && overflow_o |-> inexact_o && res_o[OW-2:0] == INF_MAG);  // R7
  AST_UFL_INEXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && underflow_o |-> inexact_o);  // R9
  AST_INVALID_NAN_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !in_nan |=> !invalid_o);  // R5
endmodule

// File: tb/sim_fp_s2h_narrow.sv
`timescale 1ns/1ps
module sim_fp_s2h_narrow;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] op_i = '0;
  logic        dn_mode_i = 1'b0;
  logic        valid_o;
  logic [15:0] res_o;
  logic        invalid_o, overflow_o, underflow_o, inexact_o;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 0;

  always #2 clk = ~clk;

  fp_s2h_narrow u0 (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .valid_i    (valid_i),
    .op_i       (op_i),
    .dn_mode_i  (dn_mode_i),
    .valid_o    (valid_o),
    .res_o      (res_o),
    .invalid_o  (invalid_o),
    .overflow_o (overflow_o),
    .underflow_o(underflow_o),
    .inexact_o  (inexact_o)
  );

  task automatic chk(input string tag, input logic [31:0] x, input logic [15:0] act,
                     input logic [15:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s op=%h act=%h exp=%h", tag, x, act, exp_v);
    end
  endtask

  // returns {result, invalid, overflow, underflow, inexact}
  function automatic logic [19:0] ref_conv(input logic [31:0] x, input logic dn);
    logic s;
    int   e, ee, sh;
    longint m, qi, rem, half, mag;
    logic inv, ovf, ufl, inx, rnd;
    logic [15:0] r;
    s = x[31];
    e = int'(x[30:23]);
    inv = 0; ovf = 0; ufl = 0; inx = 0;
    if (e == 255) begin
      if (x[22:0] == 0) r = {s, 15'h7C00};
      else begin
        inv = ~x[22];
        r = dn ? 16'h7E00 : {s, 5'h1F, 1'b1, x[21:13]};
      end
    end else if (e == 0 && x[22:0] == 0) begin
      r = {s, 15'h0};
    end else begin
      ee = (e == 0) ? -126 : e - 127;
      m  = (e == 0) ? longint'(x[22:0]) : (longint'(x[22:0]) | (64'd1 << 23));
      sh = ((ee > -14) ? ee : -14) - ee + 13;
      if (sh > 60) begin
        qi = 0; rem = 1; half = 64'h4000_0000_0000_0000;
      end else begin
        qi = m >> sh;
        rem = m - (qi << sh);
        half = 64'd1 << (sh - 1);
      end
      rnd = (rem > half) || (rem == half && qi[0]);
      inx = (rem != 0);
      mag = ((ee >= -14) ? (longint'(ee + 14) << 10) : 0) + qi + longint'(rnd);
      ufl = (ee < -14) && inx;
      if (mag >= 64'h7C00) begin
        r = {s, 15'h7C00}; ovf = 1; inx = 1;
      end else r = {s, mag[14:0]};
    end
    return {r, inv, ovf, ufl, inx};
  endfunction

  function automatic string res_tag(input logic [31:0] x, input logic dn, input logic [19:0] e);
    if (x[30:23] == 8'hFF) begin
      if (x[22:0] == 0) return "R2";
      return dn ? "R4" : "R3";
    end
    if (x[30:0] == 0) return "R1";
    if (e[2]) return "R7";
    if (x[30:23] < 8'd113) return "R8";
    return "R6";
  endfunction

  task automatic run_vec(input logic [31:0] x, input logic dn);
    logic [19:0] e;
    @(negedge clk);
    op_i = x; dn_mode_i = dn; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    e = ref_conv(x, dn);
    chk("R11 valid", x, {15'h0, valid_o}, 16'h1);
    chk(res_tag(x, dn, e), x, res_o, e[19:4]);
    chk("R5 invalid", x, {15'h0, invalid_o}, {15'h0, e[3]});
    chk("R7 overflow", x, {15'h0, overflow_o}, {15'h0, e[2]});
    chk("R9 underflow", x, {15'h0, underflow_o}, {15'h0, e[1]});
    chk("R10 inexact", x, {15'h0, inexact_o}, {15'h0, e[0]});
  endtask

  task automatic run_hard(input string tag, input logic [31:0] x, input logic dn,
                          input logic [15:0] r, input logic [3:0] f);
    run_vec(x, dn);
    chk(tag, x, res_o, r);
    chk(tag, x, {12'h0, invalid_o, overflow_o, underflow_o, inexact_o}, {12'h0, f});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 reset", 32'h0, {valid_o, invalid_o, overflow_o, underflow_o, inexact_o, 11'h0}, 16'h0);
    chk("R12 reset", 32'h0, res_o, 16'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R12 after reset", 32'h0, {15'h0, valid_o}, 16'h0);

    // directed corners with hand-derived values
    run_hard("R1 +zero", 32'h0000_0000, 1'b0, 16'h0000, 4'b0000);
    run_hard("R1 -zero", 32'h8000_0000, 1'b1, 16'h8000, 4'b0000);
    run_hard("R2 +inf",  32'h7F80_0000, 1'b0, 16'h7C00, 4'b0000);
    run_hard("R2 -inf",  32'hFF80_0000, 1'b1, 16'hFC00, 4'b0000);
    run_hard("R3 snan payload", 32'hFFA0_0000, 1'b0, 16'hFF00, 4'b1000);
    run_hard("R3 qnan payload", 32'h7FC0_2000, 1'b0, 16'h7E01, 4'b0000);
    run_hard("R4 default nan",  32'hFFA0_0000, 1'b1, 16'h7E00, 4'b1000);
    run_hard("R5 quiet no flag", 32'hFFFF_FFFF, 1'b1, 16'h7E00, 4'b0000);
    run_hard("R6 one",          32'h3F80_0000, 1'b0, 16'h3C00, 4'b0000);
    run_hard("R6 tie even down", 32'h3F80_1000, 1'b0, 16'h3C00, 4'b0001);
    run_hard("R6 tie even up",  32'h3F80_3000, 1'b0, 16'h3C02, 4'b0001);
    run_hard("R6 carry to exp", 32'h3FFF_F000, 1'b0, 16'h4000, 4'b0001);
    run_hard("R7 max half",     32'h477F_E000, 1'b0, 16'h7BFF, 4'b0000);
    run_hard("R7 just below",   32'h477F_EFFF, 1'b0, 16'h7BFF, 4'b0001);
    run_hard("R7 overflow",     32'hC77F_F000, 1'b0, 16'hFC00, 4'b0101);
    run_hard("R7 huge",         32'h7F7F_FFFF, 1'b0, 16'h7C00, 4'b0101);
    run_hard("R8 tie to zero",  32'h3300_0000, 1'b0, 16'h0000, 4'b0011);
    run_hard("R8 above half",   32'h3300_0001, 1'b0, 16'h0001, 4'b0011);
    run_hard("R9 exact sub",    32'h3380_0000, 1'b0, 16'h0001, 4'b0000);
    run_hard("R8 to min normal", 32'h387F_F000, 1'b0, 16'h0400, 4'b0011);
    run_hard("R8 input subnorm", 32'h8000_0001, 1'b0, 16'h8000, 4'b0011);
    run_hard("R10 exact normal", 32'h4049_0000, 1'b0, 16'h4248, 4'b0000);

    // R11 hold with idle input
    held = res_o;
    @(negedge clk);
    op_i = 32'h3F80_0000;
    @(negedge clk);
    chk("R11 idle valid", 32'h0, {15'h0, valid_o}, 16'h0);
    chk("R11 idle hold", 32'h0, res_o, held);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] x;
      logic [1:0]  mode;
      x = $urandom;
      mode = 2'($urandom % 4);
      case (mode)
        2'd1: x[30:23] = 8'(100 + ($urandom % 46));
        2'd2: x[30:23] = 8'hFF;
        2'd3: begin
          x[30:23] = ($urandom % 2) ? 8'(108 + ($urandom % 8)) : 8'(140 + ($urandom % 4));
          if ($urandom % 2) x[12:0] = 13'h1000;
        end
        default: ;
      endcase
      run_vec(x, 1'($urandom % 2));
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule